// File: doc/BRIEF.md
# Full/Empty Tagged Word Memory

This block is a small word-addressed data store in which every word also carries a 2-bit tag. The tag lives beside the data and is invisible to ordinary traffic. Plain loads and stores read and write the data and never look at the tag. Supervised loads and stores first inspect the tag of the addressed word. When the tag allows the access, it completes and the tag moves to its next state. When it does not, the access is refused and an exception is raised.

The tag follows a producer/consumer discipline. A supervised store fills an Empty word and marks it Full. A supervised load drains a Full word and marks it Empty. A word tagged None is not policed. A separate metadata port lets an exception handler, or initialisation code, write any tag directly.

The request port accepts one access per clock. Its response, or its exception, appears in the following cycle. Reset is asserted asynchronously and released through a two-stage synchroniser. After reset every tag reads None, and data contents are undefined until written.

Top module: `fe_tagged_mem`

## Requirements
- R1: After reset, every response output is low. Every tag is None, so a supervised load of any word completes and returns its data.
- R2: A plain access (req_super=0) completes in the cycle after the request, with rsp_done=1. Its tag is neither checked nor changed. A plain load returns the word's data. Any store returns rsp_rdata=0.
- R3: A supervised load of a word tagged Full (2'b10) completes with the word's data and sets the tag to Empty (2'b01).
- R4: A supervised store to a word tagged Empty (2'b01) writes the data and sets the tag to Full (2'b10).
- R5: A supervised load of a word tagged Empty raises an exception with rsp_rdata=0 and leaves the tag at Empty.
- R6: A supervised store to a word tagged Full raises an exception and changes neither the data nor the tag.
- R7: A word tagged None (2'b00, and 2'b11, which is read as None) accepts supervised loads and stores like plain ones and keeps its tag code unchanged.
- R8: An exception is a one-cycle pulse on rsp_exc. It comes together with rsp_exc_addr, which is the faulting address, and rsp_exc_store, which is 1 for a store and 0 for a load. Both fields are 0 when there is no exception.
- R9: A metadata write (meta_we) sets the tag of meta_addr to meta_tag at the next clock. If a request updates the same word's tag in the same cycle, the metadata write wins.
- R10: Each accepted request yields exactly one of rsp_done and rsp_exc in the next cycle. No response appears without a request, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_super | input | 1 | 1 = supervised access |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| meta_we | input | 1 | Direct tag write enable |
| meta_addr | input | ADDR_W | Tag write address |
| meta_tag | input | 2 | Tag value to write |
| rsp_rdata | output | DATA_W | Load data, 0 otherwise |
| rsp_done | output | 1 | Access completed |
| rsp_exc | output | 1 | Access refused by tag |
| rsp_exc_addr | output | ADDR_W | Faulting address |
| rsp_exc_store | output | 1 | Faulting operation was a store |

## Verification
The hardest situation to reach from the ports is a same-cycle collision: a supervised access changes a word's tag while the metadata port writes that same word. Only the order between the two updates decides the final tag. The bench drives this collision on purpose in a directed step. It then also drives it randomly, by sharing one narrow address range between the request and metadata ports. Reaching the refused cases of R5 and R6 requires first driving a word into the right tag. The bench does this either through the metadata port or through a chain of supervised accesses, and it checks every cycle against a behavioural model of data and tags.

// File: rtl/fe_pkg.sv
package fe_pkg;
  typedef enum logic [1:0] {
    TAG_NONE  = 2'b00,
    TAG_EMPTY = 2'b01,
    TAG_FULL  = 2'b10,
    TAG_NONE2 = 2'b11
  } tag_e;
endpackage

// File: rtl/fe_rst_sync.sv
module fe_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/fe_access_ctrl.sv
module fe_access_ctrl
  import fe_pkg::*;
(
  input  logic       acc_valid,
  input  logic       acc_store,
  input  logic       acc_super,
  input  logic [1:0] cur_tag,
  output logic       acc_ok,
  output logic       acc_exc,
  output logic       data_we,
  output logic       tag_we,
  output logic [1:0] tag_new
);
  always_comb begin
    acc_ok  = 1'b0;
    acc_exc = 1'b0;
    tag_we  = 1'b0;
    tag_new = cur_tag;
    if (acc_valid) begin
      if (!acc_super) begin
        acc_ok = 1'b1;
      end else if (acc_store) begin
        unique case (tag_e'(cur_tag))
          TAG_EMPTY: begin acc_ok = 1'b1; tag_we = 1'b1; tag_new = TAG_FULL; end
          TAG_FULL:  acc_exc = 1'b1;
          default:   acc_ok = 1'b1;
        endcase
      end else begin
        unique case (tag_e'(cur_tag))
          TAG_FULL:  begin acc_ok = 1'b1; tag_we = 1'b1; tag_new = TAG_EMPTY; end
          TAG_EMPTY: acc_exc = 1'b1;
          default:   acc_ok = 1'b1;
        endcase
      end
    end
    data_we = acc_ok & acc_store;
  end
endmodule

// File: rtl/fe_tag_store.sv
module fe_tag_store #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        rd_tag,
  input  logic              upd_we,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [1:0]        upd_tag,
  input  logic              meta_we,
  input  logic [ADDR_W-1:0] meta_addr,
  input  logic [1:0]        meta_tag
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [1:0] tag_q [DEPTH];
  logic [1:0] tag_d [DEPTH];
  logic       tag_en [DEPTH];

  assign rd_tag = tag_q[rd_addr];

  // Next-state per entry: metadata port has priority over access update.
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_comb begin
      tag_en[i] = 1'b0;
      tag_d[i]  = tag_q[i];
      if (meta_we && meta_addr == ADDR_W'(i)) begin
        tag_en[i] = 1'b1;
        tag_d[i]  = meta_tag;
      end else if (upd_we && upd_addr == ADDR_W'(i)) begin
        tag_en[i] = 1'b1;
        tag_d[i]  = upd_tag;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         tag_q[i] <= 2'b00;
      else if (tag_en[i]) tag_q[i] <= tag_d[i];
    end
  end
endmodule

// File: rtl/fe_data_store.sv
module fe_data_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  assign rdata = mem_q[addr];

  always_ff @(posedge clk) begin
    if (we) mem_q[addr] <= wdata;
  end
endmodule

// File: rtl/fe_tagged_mem.sv
module fe_tagged_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic              req_super,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              meta_we,
  input  logic [ADDR_W-1:0] meta_addr,
  input  logic [1:0]        meta_tag,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic              rsp_exc,
  output logic [ADDR_W-1:0] rsp_exc_addr,
  output logic              rsp_exc_store
);
  logic              rst_sync_n;
  logic [1:0]        cur_tag;
  logic              acc_ok, acc_exc, data_we, tag_we;
  logic [1:0]        tag_new;
  logic [DATA_W-1:0] mem_rdata;

  logic [DATA_W-1:0] rdata_d;
  logic              done_d, exc_d, exc_store_d;
  logic [ADDR_W-1:0] exc_addr_d;

  fe_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  fe_tag_store #(.ADDR_W(ADDR_W)) u_tags (
    .clk(clk), .rst_n(rst_sync_n),
    .rd_addr(req_addr), .rd_tag(cur_tag),
    .upd_we(tag_we), .upd_addr(req_addr), .upd_tag(tag_new),
    .meta_we(meta_we), .meta_addr(meta_addr), .meta_tag(meta_tag)
  );

  fe_access_ctrl u_ctrl (
    .acc_valid(req_valid), .acc_store(req_store), .acc_super(req_super),
    .cur_tag(cur_tag), .acc_ok(acc_ok), .acc_exc(acc_exc),
    .data_we(data_we), .tag_we(tag_we), .tag_new(tag_new)
  );

  fe_data_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .addr(req_addr), .we(data_we),
    .wdata(req_wdata), .rdata(mem_rdata)
  );

  always_comb begin
    done_d      = acc_ok;
    exc_d       = acc_exc;
    rdata_d     = (acc_ok && !req_store) ? mem_rdata : '0;
    exc_addr_d  = acc_exc ? req_addr : '0;
    exc_store_d = acc_exc & req_store;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_rdata     <= '0;
      rsp_done      <= 1'b0;
      rsp_exc       <= 1'b0;
      rsp_exc_addr  <= '0;
      rsp_exc_store <= 1'b0;
    end else begin
      rsp_rdata     <= rdata_d;
      rsp_done      <= done_d;
      rsp_exc       <= exc_d;
      rsp_exc_addr  <= exc_addr_d;
      rsp_exc_store <= exc_store_d;
    end
  end
endmodule

// File: rtl/fe_tagged_mem_chk.sv
module fe_tagged_mem_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_store,
  input logic              req_super,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_done,
  input logic              rsp_exc,
  input logic [ADDR_W-1:0] rsp_exc_addr,
  input logic              rsp_exc_store
);
  logic              pv_q, ps_q, pst_q;
  logic [ADDR_W-1:0] pa_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q <= 1'b0; ps_q <= 1'b0; pst_q <= 1'b0; pa_q <= '0;
    end else begin
      pv_q <= req_valid; ps_q <= req_super; pst_q <= req_store; pa_q <= req_addr;
    end
  end

  AST_DONE_EXC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_done && rsp_exc)); // R10
  AST_RSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done || rsp_exc) |-> pv_q); // R10
  AST_REQ_GETS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    pv_q |-> (rsp_done || rsp_exc)); // R10
  AST_PLAIN_NO_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    (pv_q && !ps_q) |-> rsp_done); // R2
  AST_EXC_ONLY_SUPER: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_exc |-> ps_q); // R8
  AST_EXC_INFO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_exc |-> (rsp_exc_addr == pa_q && rsp_exc_store == pst_q)); // R8
  AST_EXC_INFO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_exc |-> (rsp_exc_addr == '0 && !rsp_exc_store)); // R8
  AST_EXC_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_exc |-> rsp_rdata == '0); // R5
  AST_STORE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && pst_q) |-> rsp_rdata == '0); // R2
endmodule

bind fe_tagged_mem fe_tagged_mem_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .req_valid(req_valid), .req_store(req_store), .req_super(req_super),
  .req_addr(req_addr), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
  .rsp_exc(rsp_exc), .rsp_exc_addr(rsp_exc_addr), .rsp_exc_store(rsp_exc_store)
);

// File: tb/fe_tagged_mem_tb.sv
module fe_tagged_mem_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int WATCHDOG = 20000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_store, req_super;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic              meta_we;
  logic [ADDR_W-1:0] meta_addr;
  logic [1:0]        meta_tag;
  logic [DATA_W-1:0] rsp_rdata;
  logic              rsp_done, rsp_exc, rsp_exc_store;
  logic [ADDR_W-1:0] rsp_exc_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  fe_tagged_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (.*);

  // Behavioural model state
  logic [DATA_W-1:0] m_data [DEPTH];
  logic [1:0]        m_tag  [DEPTH];
  logic [DATA_W-1:0] e_rdata;
  logic              e_done, e_exc, e_exc_store;
  logic [ADDR_W-1:0] e_exc_addr;
  string             e_req;
  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(e_req, "rsp_done", rsp_done, e_done);
    chk(e_req, "rsp_exc", rsp_exc, e_exc);
    chk(e_req, "rsp_rdata", rsp_rdata, e_rdata);
    chk(e_req, "rsp_exc_addr", rsp_exc_addr, e_exc_addr);
    chk(e_req, "rsp_exc_store", rsp_exc_store, e_exc_store);
  endtask

  // One cycle: at the falling edge compare the previous response, then drive
  // a new request and predict its response.
  task automatic step(input bit v, input bit st, input bit su, input int a,
                      input logic [DATA_W-1:0] wd, input bit mw, input int ma,
                      input logic [1:0] mt, input string lbl = "");
    logic [1:0] t;
    @(negedge clk);
    compare();
    req_valid = v; req_store = st; req_super = su;
    req_addr = ADDR_W'(a); req_wdata = wd;
    meta_we = mw; meta_addr = ADDR_W'(ma); meta_tag = mt;
    e_done = 0; e_exc = 0; e_rdata = '0; e_exc_addr = '0; e_exc_store = 0;
    e_req = "R10";
    if (v) begin
      t = m_tag[a];
      if (!su) begin
        e_req = "R2"; e_done = 1;
        if (st) m_data[a] = wd; else e_rdata = m_data[a];
      end else if (t == 2'b00 || t == 2'b11) begin
        e_req = "R7"; e_done = 1;
        if (st) m_data[a] = wd; else e_rdata = m_data[a];
      end else if (!st && t == 2'b10) begin
        e_req = "R3"; e_done = 1; e_rdata = m_data[a]; m_tag[a] = 2'b01;
      end else if (st && t == 2'b01) begin
        e_req = "R4"; e_done = 1; m_data[a] = wd; m_tag[a] = 2'b10;
      end else begin
        e_req = st ? "R6/R8" : "R5/R8";
        e_exc = 1; e_exc_addr = ADDR_W'(a); e_exc_store = st;
      end
    end
    if (mw) begin
      m_tag[ma] = mt;
      if (v && ma == a) e_req = {e_req, "+R9"};
    end
    if (lbl != "") e_req = lbl;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, '0, 0, 0, 2'b00);
  endtask

  initial begin
    req_valid = 0; req_store = 0; req_super = 0; req_addr = '0; req_wdata = '0;
    meta_we = 0; meta_addr = '0; meta_tag = 2'b00;
    e_done = 0; e_exc = 0; e_rdata = '0; e_exc_addr = '0; e_exc_store = 0;
    e_req = "R1";
    for (int i = 0; i < DEPTH; i++) begin m_data[i] = '0; m_tag[i] = 2'b00; end
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    // R1: outputs idle after reset
    step(0, 0, 0, 0, '0, 0, 0, 2'b00, "R1");
    // R2: plain stores fill data; tags untouched
    for (int i = 0; i < DEPTH; i++) step(1, 1, 0, i, 32'hA000_0000 + i, 0, 0, 2'b00);
    // R1: all tags None, supervised loads complete
    for (int i = 0; i < DEPTH; i++) step(1, 0, 1, i, '0, 0, 0, 2'b00, "R1");
    // R9 then R3, R5, R4, R6 on word 3
    step(0, 0, 0, 0, '0, 1, 3, 2'b10, "R9");
    step(1, 0, 1, 3, '0, 0, 0, 2'b00);          // R3
    step(1, 0, 1, 3, '0, 0, 0, 2'b00);          // R5
    step(1, 1, 1, 3, 32'h1234_5678, 0, 0, 2'b00); // R4
    step(1, 1, 1, 3, 32'hDEAD_BEEF, 0, 0, 2'b00); // R6
    step(1, 0, 0, 3, '0, 0, 0, 2'b00);          // R2 data unchanged by R6
    step(1, 0, 1, 3, '0, 0, 0, 2'b00);          // R3 tag still Full after R6
    // R2: plain accesses on an Empty word leave it Empty
    step(1, 1, 0, 3, 32'h5555_0000, 0, 0, 2'b00);
    step(1, 0, 0, 3, '0, 0, 0, 2'b00);
    step(1, 0, 1, 3, '0, 0, 0, 2'b00);          // R5 still Empty
    // R7: code 2'b11 behaves as None and stays 2'b11
    step(0, 0, 0, 0, '0, 1, 5, 2'b11, "R9");
    step(1, 1, 1, 5, 32'h0BAD_CAFE, 0, 0, 2'b00);
    step(1, 0, 1, 5, '0, 0, 0, 2'b00);
    step(1, 0, 1, 5, '0, 0, 0, 2'b00);
    // R9: collision, metadata write wins over access tag update
    step(0, 0, 0, 0, '0, 1, 7, 2'b01, "R9");
    step(1, 1, 1, 7, 32'h7777_7777, 1, 7, 2'b01); // R4 data written, tag forced Empty
    step(1, 0, 1, 7, '0, 0, 0, 2'b00);           // R5 proves Empty
    // R8: back-to-back exceptions on different addresses
    step(0, 0, 0, 0, '0, 1, 9, 2'b10, "R9");
    step(1, 1, 1, 9, 32'h1, 0, 0, 2'b00);
    step(1, 0, 1, 7, '0, 0, 0, 2'b00);
    idle(2);
    // Mixed random traffic on a narrow address range
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 8) != 0, $urandom % 2, ($urandom % 4) != 0, $urandom % 4,
           $urandom, ($urandom % 5) == 0, $urandom % 4, 2'($urandom));
    end
    idle(2);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule